// File: doc/BRIEF.md
# Byte-Command Configuration Register Interface

This block sits on a configuration byte stream and turns short, fixed-length command packets into updates of a small register file. A write packet of four bytes changes one register. A read packet of three bytes gets exactly one reply byte on a separate response stream. Both packet kinds carry a fixed filler byte in second position, which the decoder consumes but does not interpret.

The registers drive the capture path. Two bytes form a 16-bit probe enable mask. One byte selects the base clock, either a 100 MHz or a 160 MHz base. One byte holds a divider value N. A sample strobe is derived from the fast clock and pulses once every N+1 cycles, so the capture rate is the base rate divided by N+1. For example, N=0x09 on the 100 MHz base gives 10 MHz, and N=0x01 on the 160 MHz base gives 80 MHz. Writing the divider or the base select restarts the strobe count, so that no short period is emitted.

Top module: `cfgr_top`

## Requirements
- R1: After reset every register reads 0x00. probeMask, divN and baseSel are 0 and rspValid is low.
- R2: A write packet is the bytes 0x80, filler, address, data, and the filler is not interpreted. Address 0x02 writes probeMask[7:0], address 0x03 writes probeMask[15:8] and address 0x04 writes divN. The new value is visible in the cycle after the data byte.
- R3: A read packet is the bytes 0x81, filler, address. In the cycle after the address byte, rspValid is high for one cycle and rspByte holds the current contents of that register.
- R4: A write to an unmapped address (anything other than 0x02, 0x03, 0x04 or 0x0a) changes no output. A read of an unmapped address returns 0x00.
- R5: When no packet is in progress, a byte other than 0x80 or 0x81 is dropped. The next byte is decoded as a possible opcode.
- R6: A byte is consumed only in a cycle with cmdValid high. Idle cycles inside a packet neither advance nor abort it.
- R7: sampleStrobe is a one-cycle pulse every divN+1 clock cycles. With divN=0 it stays high in every cycle.
- R8: A write to address 0x04 or 0x0a restarts the divider. sampleStrobe is low in the cycle after the data byte, and the first pulse comes exactly divN+1 cycles after the write edge.
- R9: baseSel equals bit 0 of register 0x0a: 0 selects the 100 MHz base and 1 selects the 160 MHz base. A read of 0x0a returns the full byte.
- R10: rspValid is raised once per read packet and never for a write packet or a dropped byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdByte | input | 8 | Command stream byte |
| cmdValid | input | 1 | cmdByte is present this cycle |
| rspByte | output | 8 | Reply byte for a read packet |
| rspValid | output | 1 | rspByte is valid this cycle |
| probeMask | output | 16 | Probe enable mask {reg 0x03, reg 0x02} |
| divN | output | 8 | Divider value N (reg 0x04) |
| baseSel | output | 1 | Base clock select, 0 = 100 MHz, 1 = 160 MHz |
| sampleStrobe | output | 1 | Sample pacing pulse, one per divN+1 cycles |

## Verification
The bench checks the strobe timing after divider and base writes. A decoder that skipped the reload would give a first period that is short or long, and the bench counts that period exactly. It sends stray non-opcode bytes between packets. A decoder that failed to resynchronise would treat the filler or the address as an opcode, and the following read would return a wrong byte or no byte at all. It also spreads packets over idle cycles, which exposes a decoder that advances on invalid cycles. Reads and writes to unmapped addresses check that no aliasing onto a real register occurs and that the reply is zero.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  localparam int BYTE_W = 8;
  localparam int MASK_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h80;
  localparam logic [BYTE_W-1:0] OP_READ   = 8'h81;
  localparam logic [BYTE_W-1:0] ADR_MASKL = 8'h02;
  localparam logic [BYTE_W-1:0] ADR_MASKH = 8'h03;
  localparam logic [BYTE_W-1:0] ADR_DIV   = 8'h04;
  localparam logic [BYTE_W-1:0] ADR_BASE  = 8'h0a;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_FILL, S_WR_ADDR, S_WR_DATA, S_RD_FILL, S_RD_ADDR
  } pktState_e;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [BYTE_W-1:0] addr;
  } cfgStrobe_t;
endpackage

// File: rtl/cfgr_ctrl.sv
module cfgr_ctrl
  import cfgr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic              cmdValid,
  output cfgStrobe_t        stb
);
  pktState_e         state;
  logic [BYTE_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      addrQ <= '0;
    end else if (cmdValid) begin
      unique case (state)
        S_IDLE: begin
          if (cmdByte == OP_WRITE)     state <= S_WR_FILL;
          else if (cmdByte == OP_READ) state <= S_RD_FILL;
        end
        S_WR_FILL: state <= S_WR_ADDR;
        S_WR_ADDR: begin
          addrQ <= cmdByte;
          state <= S_WR_DATA;
        end
        S_WR_DATA: state <= S_IDLE;
        S_RD_FILL: state <= S_RD_ADDR;
        S_RD_ADDR: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.wrEn = cmdValid && (state == S_WR_DATA);
    stb.rdEn = cmdValid && (state == S_RD_ADDR);
    stb.addr = (state == S_RD_ADDR) ? cmdByte : addrQ;
  end
endmodule

// File: rtl/cfgr_divider.sv
module cfgr_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reload,
  input  logic [W-1:0] limit,
  output logic         strobe
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (reload) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (cnt == limit) begin
      cnt    <= '0;
      strobe <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgr_dp.sv
module cfgr_dp
  import cfgr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rspByte,
  output logic              rspValid,
  output logic [MASK_W-1:0] probeMask,
  output logic [BYTE_W-1:0] divN,
  output logic              baseSel,
  output logic              sampleStrobe
);
  localparam int NREG = 4;
  localparam logic [NREG*BYTE_W-1:0] ADR_LIST = {ADR_BASE, ADR_DIV, ADR_MASKH, ADR_MASKL};

  logic [BYTE_W-1:0] regQ [NREG];
  logic [NREG-1:0]   hit;
  logic [BYTE_W-1:0] rdMux;
  logic              reload;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hit[i] = (stb.addr == ADR_LIST[i*BYTE_W +: BYTE_W]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                regQ[i] <= '0;
      else if (stb.wrEn && hit[i]) regQ[i] <= wrData;
    end
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rdMux = regQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspByte  <= '0;
    end else begin
      rspValid <= stb.rdEn;
      if (stb.rdEn) rspByte <= rdMux;
    end
  end

  assign reload    = stb.wrEn && (hit[2] || hit[3]);
  assign probeMask = {regQ[1], regQ[0]};
  assign divN      = regQ[2];
  assign baseSel   = regQ[3][0];

  cfgr_divider #(.W(BYTE_W)) u_div (
    .clk    (clk),
    .rstN   (rstN),
    .reload (reload),
    .limit  (regQ[2]),
    .strobe (sampleStrobe)
  );
endmodule

// File: rtl/cfgr_top.sv
module cfgr_top
  import cfgr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic              cmdValid,
  output logic [BYTE_W-1:0] rspByte,
  output logic              rspValid,
  output logic [MASK_W-1:0] probeMask,
  output logic [BYTE_W-1:0] divN,
  output logic              baseSel,
  output logic              sampleStrobe
);
  cfgStrobe_t stbBus;

  cfgr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdByte  (cmdByte),
    .cmdValid (cmdValid),
    .stb      (stbBus)
  );

  cfgr_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stbBus),
    .wrData       (cmdByte),
    .rspByte      (rspByte),
    .rspValid     (rspValid),
    .probeMask    (probeMask),
    .divN         (divN),
    .baseSel      (baseSel),
    .sampleStrobe (sampleStrobe)
  );
endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker
  import cfgr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input cfgStrobe_t        stb,
  input logic              cmdValid,
  input logic              rspValid,
  input logic [BYTE_W-1:0] rspByte,
  input logic              sampleStrobe,
  input logic [BYTE_W-1:0] divN,
  input logic [MASK_W-1:0] probeMask
);
  // R10: a reply lasts one cycle
  a_r10_single_reply: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R3: a reply follows a consumed address byte
  a_r3_reply_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(cmdValid));

  // R4: unmapped reads answer zero
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.addr != ADR_MASKL && stb.addr != ADR_MASKH &&
     stb.addr != ADR_DIV && stb.addr != ADR_BASE) |=> (rspValid && rspByte == '0));

  // R2: the mask moves only on a write
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> $stable(probeMask));

  // R8: a divider or base write restarts the strobe
  a_r8_reload_low: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && (stb.addr == ADR_DIV || stb.addr == ADR_BASE)) |=> !sampleStrobe);

  // R7: with N above zero the strobe is a single-cycle pulse
  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && divN != '0) |=> !sampleStrobe);
endmodule

bind cfgr_top cfgr_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .stb          (stbBus),
  .cmdValid     (cmdValid),
  .rspValid     (rspValid),
  .rspByte      (rspByte),
  .sampleStrobe (sampleStrobe),
  .divN         (divN),
  .probeMask    (probeMask)
);

// File: tb/tb_cfgr_top.sv
module tb_cfgr_top;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cmdByte = 8'h00;
  logic        cmdValid = 1'b0;
  logic [7:0]  rspByte;
  logic        rspValid;
  logic [15:0] probeMask;
  logic [7:0]  divN;
  logic        baseSel;
  logic        sampleStrobe;

  int checks = 0;
  int errors = 0;
  int rspSeen = 0;
  int readsSent = 0;

  always #(CLK_P/2) clk = ~clk;

  cfgr_top dut (.*);

  // behavioural reference
  int mReg [int];
  int mPhase = 0;
  bit mIsWr = 0;
  int mAddr = 0;
  int mSince = 0;
  bit eRspValid = 0;
  int eRsp = 0;
  bit eStrobe = 0;

  function automatic bit mapped(int a);
    return (a == 2) || (a == 3) || (a == 4) || (a == 10);
  endfunction

  function automatic int rd(int a);
    return (mapped(a) && mReg.exists(a)) ? mReg[a] : 0;
  endfunction

  always @(posedge clk) begin
    bit reload;
    reload = 0;
    if (!rstN) begin
      mReg.delete(); mPhase = 0; mSince = 0; eRspValid = 0; eStrobe = 0;
    end else begin
      eRspValid = 0;
      if (cmdValid) begin
        case (mPhase)
          0: if (cmdByte == 8'h80) begin mPhase = 1; mIsWr = 1; end
             else if (cmdByte == 8'h81) begin mPhase = 1; mIsWr = 0; end
          1: mPhase = 2;
          2: if (mIsWr) begin mAddr = cmdByte; mPhase = 3; end
             else begin eRspValid = 1; eRsp = rd(cmdByte); mPhase = 0; end
          default: begin
            if (mapped(mAddr)) mReg[mAddr] = cmdByte;
            if (mAddr == 4 || mAddr == 10) reload = 1;
            mPhase = 0;
          end
        endcase
      end
      if (reload) mSince = 0; else mSince++;
      eStrobe = (mSince > 0) && ((mSince % (rd(4) + 1)) == 0);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 probeMask", probeMask, (rd(3) << 8) | rd(2));
      check("R2 divN", divN, rd(4));
      check("R9 baseSel", baseSel, rd(10) & 1);
      check("R7 sampleStrobe", sampleStrobe, eStrobe);
      check("R10 rspValid", rspValid, eRspValid);
      if (eRspValid) check("R3 rspByte", rspByte, eRsp);
      if (rspValid) rspSeen++;
    end
  end

  task automatic sendByte(logic [7:0] b, int gap = 0);
    cmdByte = b; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; cmdByte = 8'hA5;
    repeat (gap) @(negedge clk);
  endtask

  task automatic writeReg(logic [7:0] a, logic [7:0] d, int gap = 0);
    sendByte(8'h80, gap); sendByte(8'h01, gap); sendByte(a, gap);
    cmdByte = d; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic readReg(logic [7:0] a, output logic [7:0] r);
    sendByte(8'h81); sendByte(8'h01);
    cmdByte = a; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    readsSent++;
    checks++;
    if (!rspValid) begin
      errors++;
      $display("FAIL R3 rspValid actual=0 expected=1 addr=0x%0h", a);
    end
    r = rspByte;
  endtask

  task automatic strobeGap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sampleStrobe && n < 600);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 probeMask", probeMask, 0);
    check("R1 divN", divN, 0);
    check("R1 baseSel", baseSel, 0);
    check("R1 rspValid", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    readReg(8'h04, r); check("R1 reg04", r, 0);

    // R2 probe mask patterns
    writeReg(8'h02, 8'h07); writeReg(8'h03, 8'h00);
    check("R2 mask3", probeMask, 16'h0007);
    writeReg(8'h02, 8'hff); writeReg(8'h03, 8'h01);
    check("R2 mask9", probeMask, 16'h01ff);
    writeReg(8'h03, 8'hff);
    check("R2 mask16", probeMask, 16'hffff);
    // R2 filler byte is not interpreted
    sendByte(8'h80); sendByte(8'h5c); sendByte(8'h02); sendByte(8'h3f);
    check("R2 filler", probeMask, 16'hff3f);

    // R3 read back
    readReg(8'h02, r); check("R3 read02", r, 8'h3f);
    readReg(8'h03, r); check("R3 read03", r, 8'hff);

    // R8 and R7 divider timing
    writeReg(8'h04, 8'h09);
    check("R8 low after write", sampleStrobe, 0);
    strobeGap(n); check("R8 first period", n, 10);
    strobeGap(n); check("R7 period N=9", n, 10);
    writeReg(8'h04, 8'hc7);
    strobeGap(n); check("R8 first period N=199", n, 200);
    strobeGap(n); check("R7 period N=199", n, 200);
    writeReg(8'h04, 8'h01);
    strobeGap(n); check("R7 period N=1", n, 2);

    // R9 base select and reload on base write
    repeat (1) @(negedge clk);
    writeReg(8'h0a, 8'h01);
    check("R9 baseSel", baseSel, 1);
    check("R8 base write low", sampleStrobe, 0);
    strobeGap(n); check("R8 after base write", n, 2);
    readReg(8'h0a, r); check("R9 read0a", r, 8'h01);

    // R4 unmapped
    writeReg(8'h05, 8'h55);
    check("R4 mask kept", probeMask, 16'hff3f);
    check("R4 div kept", divN, 8'h01);
    readReg(8'h05, r); check("R4 read05", r, 0);
    readReg(8'h12, r); check("R4 read12", r, 0);

    // R5 stray bytes then packets
    sendByte(8'h33); sendByte(8'h01); sendByte(8'h02);
    readReg(8'h02, r); check("R5 resync read", r, 8'h3f);
    sendByte(8'h7f);
    writeReg(8'h03, 8'h12);
    check("R5 resync write", probeMask, 16'h123f);

    // R6 packets with idle gaps
    writeReg(8'h02, 8'h66, 3);
    check("R6 gapped write", probeMask, 16'h1266);
    writeReg(8'h04, 8'h00, 2);
    @(negedge clk);
    check("R7 N=0 high", sampleStrobe, 1);
    @(negedge clk);
    check("R7 N=0 stays high", sampleStrobe, 1);

    repeat (3) @(negedge clk);
    check("R10 reply count", rspSeen, readsSent);
    finishRun();
  end
endmodule